// File: doc/BRIEF.md
# Pilot-Tone Digital Timing PLL

This block follows the slow drift between a remote transmitter's sample clock and the local receive sample clock. Once per received symbol, a phase detector outside the block presents a signed phase-error value measured on the pilot tone, together with a one-cycle symbol strobe. A proportional-integral loop filter with shift-based gains turns the error stream into a running estimate of the frequency offset. A signed phase accumulator gathers the residual phase that the estimate and the proportional term imply.

Correction is split into two paths. While the accumulated phase stays within one sample period, it is reported as a rotation angle for a frequency-domain rotor, which turns the constellation back into place. When the accumulated phase moves past one sample period in either direction, the block raises a one-cycle request to the sample path, to drop a sample when the phase runs ahead or to insert one when it lags. In the same cycle it removes one period from the accumulator. The length of a sample period in accumulator units is a programmable input.

Each symbol is processed by a four-state controller. IDLE waits for the strobe (IDLE to FILT on an accepted strobe, otherwise IDLE stays). FILT updates the integrator and the proportional term (FILT to ACCUM, always). ACCUM adds both into the accumulator (ACCUM to CORR, always). CORR performs the period comparison, any correction, and the rotor update (CORR to IDLE, always). A synchronous clear sends every state back to IDLE.

Top module: `pilot_timing_pll`

## Requirements
- R1: While rst_n is low, freq_est, rotor_angle and the accumulator are zero, drop_pulse and insert_pulse are low, and the controller is in IDLE.
- R2: A sym_stb sampled high in IDLE at clock edge k captures phase_err. sym_stb at edges k+1, k+2 and k+3 is ignored. The next strobe is accepted at edge k+4 at the earliest.
- R3: At edge k+1, freq_est becomes freq_est + (phase_err >>> ki_shift), where >>> is an arithmetic right shift. The result saturates to the range [-2^(ACC_W-1), 2^(ACC_W-1)-1].
- R4: At edge k+2, the accumulator becomes accumulator + freq_est (the value updated at k+1) + (phase_err >>> kp_shift), saturating to the same range.
- R5: At edge k+3, if the accumulator is greater than samp_period, drop_pulse is high for exactly the following cycle and samp_period is subtracted from the accumulator.
- R6: At edge k+3, if the accumulator is less than -samp_period, insert_pulse is high for exactly the following cycle and samp_period is added to the accumulator.
- R7: An accumulator exactly equal to +samp_period or -samp_period produces no pulse and is left unchanged.
- R8: rotor_angle takes the post-correction accumulator value at edge k+3 and keeps its value at every other edge, except on a clear or reset.
- R9: drop_pulse and insert_pulse are never high together, and neither is high for two consecutive cycles.
- R10: clr sampled high zeroes freq_est, rotor_angle and the accumulator, drops the pulses and returns the controller to IDLE. It takes priority over a strobe in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear of loop state |
| sym_stb | input | 1 | Symbol strobe accompanying phase_err |
| phase_err | input | ERR_W | Signed pilot-tone phase-error metric |
| kp_shift | input | SH_W | Proportional gain as a right-shift count |
| ki_shift | input | SH_W | Integral gain as a right-shift count |
| samp_period | input | ACC_W-1 | One sample period in accumulator units (unsigned) |
| freq_est | output | ACC_W | Signed frequency-offset estimate (integrator) |
| rotor_angle | output | ACC_W | Signed residual phase for the rotor |
| drop_pulse | output | 1 | One-cycle request to delete one sample |
| insert_pulse | output | 1 | One-cycle request to insert one sample |

## Verification
The bench builds the block with ERR_W=12, SH_W=4 and ACC_W=16. With this narrow accumulator, a full-scale error at zero integral shift drives the integrator and the accumulator into both saturation limits within a few dozen symbols. This makes the clamping, and an insert issued from the negative limit, observable in a short run. The 4-bit shift fields let the random phase sweep every gain from no shift up to a shift of 15, which truncates a positive error to zero and a negative one to -1. Period values of 100 and 3000 place the exact-boundary cases and repeated drop and insert sequences within a few symbols.

// File: rtl/tpll_pkg.sv
package tpll_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FILT  = 2'd1,
        ST_ACCUM = 2'd2,
        ST_CORR  = 2'd3
    } tpll_state_t;
endpackage

// File: rtl/tpll_ctrl.sv
module tpll_ctrl
    import tpll_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic sym_stb,
    output logic err_ld,
    output logic filt_en,
    output logic acc_en,
    output logic corr_en
);
    tpll_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   state_q <= ST_IDLE;
        else if (clr) state_q <= ST_IDLE;
        else          state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (sym_stb) state_d = ST_FILT;
            ST_FILT:  state_d = ST_ACCUM;
            ST_ACCUM: state_d = ST_CORR;
            ST_CORR:  state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        err_ld  = 1'b0;
        filt_en = 1'b0;
        acc_en  = 1'b0;
        corr_en = 1'b0;
        unique case (state_q)
            ST_IDLE:  err_ld  = sym_stb;
            ST_FILT:  filt_en = 1'b1;
            ST_ACCUM: acc_en  = 1'b1;
            ST_CORR:  corr_en = 1'b1;
        endcase
    end

    // R2
    filt_to_acc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (filt_en && !clr) |=> acc_en);
    // R2
    acc_to_corr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && !clr) |=> corr_en);
    // R10
    clr_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (!filt_en && !acc_en && !corr_en));
endmodule

// File: rtl/tpll_loop_filter.sv
module tpll_loop_filter #(
    parameter int ERR_W = 12,
    parameter int ACC_W = 20,
    parameter int SH_W  = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clr,
    input  logic                    err_ld,
    input  logic                    filt_en,
    input  logic signed [ERR_W-1:0] phase_err,
    input  logic [SH_W-1:0]         kp_shift,
    input  logic [SH_W-1:0]         ki_shift,
    output logic signed [ACC_W-1:0] integ,
    output logic signed [ACC_W-1:0] prop
);
    localparam logic signed [ACC_W-1:0] MAX_V = {1'b0, {(ACC_W-1){1'b1}}};
    localparam logic signed [ACC_W-1:0] MIN_V = {1'b1, {(ACC_W-1){1'b0}}};

    logic signed [ERR_W-1:0] err_q;
    logic signed [ACC_W-1:0] err_x, i_step, p_step, integ_nx;
    logic signed [ACC_W:0]   sum;

    assign err_x  = {{(ACC_W-ERR_W){err_q[ERR_W-1]}}, err_q};
    assign i_step = err_x >>> ki_shift;
    assign p_step = err_x >>> kp_shift;
    assign sum    = {integ[ACC_W-1], integ} + {i_step[ACC_W-1], i_step};

    always_comb begin
        if (sum[ACC_W] != sum[ACC_W-1]) integ_nx = sum[ACC_W] ? MIN_V : MAX_V;
        else                            integ_nx = sum[ACC_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            err_q <= '0;
            integ <= '0;
            prop  <= '0;
        end else if (clr) begin
            err_q <= '0;
            integ <= '0;
            prop  <= '0;
        end else begin
            if (err_ld) err_q <= phase_err;
            if (filt_en) begin
                integ <= integ_nx;
                prop  <= p_step;
            end
        end
    end

    // R3
    integ_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!filt_en && !clr) |=> $stable(integ));
endmodule

// File: rtl/tpll_phase_acc.sv
module tpll_phase_acc #(
    parameter int ACC_W = 20
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clr,
    input  logic                    acc_en,
    input  logic                    corr_en,
    input  logic signed [ACC_W-1:0] integ,
    input  logic signed [ACC_W-1:0] prop,
    input  logic [ACC_W-2:0]        period,
    output logic signed [ACC_W-1:0] rotor,
    output logic                    drop,
    output logic                    ins
);
    localparam int SW = ACC_W + 2;
    localparam logic signed [ACC_W-1:0] MAX_V = {1'b0, {(ACC_W-1){1'b1}}};
    localparam logic signed [ACC_W-1:0] MIN_V = {1'b1, {(ACC_W-1){1'b0}}};

    logic signed [ACC_W-1:0] acc_q, acc_nx, per_s, neg_per;
    logic signed [SW-1:0]    sum3;

    assign per_s   = {1'b0, period};
    assign neg_per = -per_s;
    assign sum3    = SW'(acc_q) + SW'(integ) + SW'(prop);

    always_comb begin
        if (sum3[SW-1:ACC_W-1] != {3{sum3[SW-1]}}) acc_nx = sum3[SW-1] ? MIN_V : MAX_V;
        else                                       acc_nx = sum3[ACC_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= '0;
            rotor <= '0;
            drop  <= 1'b0;
            ins   <= 1'b0;
        end else if (clr) begin
            acc_q <= '0;
            rotor <= '0;
            drop  <= 1'b0;
            ins   <= 1'b0;
        end else begin
            drop <= 1'b0;
            ins  <= 1'b0;
            if (acc_en) acc_q <= acc_nx;
            if (corr_en) begin
                if (acc_q > per_s) begin
                    acc_q <= acc_q - per_s;
                    rotor <= acc_q - per_s;
                    drop  <= 1'b1;
                end else if (acc_q < neg_per) begin
                    acc_q <= acc_q + per_s;
                    rotor <= acc_q + per_s;
                    ins   <= 1'b1;
                end else begin
                    rotor <= acc_q;
                end
            end
        end
    end

    // R5
    drop_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        drop |-> (acc_q == $past(acc_q) - $past(per_s)));
    // R6
    ins_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ins |-> (acc_q == $past(acc_q) + $past(per_s)));
    // R9
    pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(drop && ins));
    // R9
    drop_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        drop |=> !drop);
    // R9
    ins_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ins |=> !ins);
    // R8
    rotor_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!corr_en && !clr) |=> $stable(rotor));
endmodule

// File: rtl/pilot_timing_pll.sv
module pilot_timing_pll #(
    parameter int ERR_W = 12,
    parameter int ACC_W = 20,
    parameter int SH_W  = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clr,
    input  logic                    sym_stb,
    input  logic signed [ERR_W-1:0] phase_err,
    input  logic [SH_W-1:0]         kp_shift,
    input  logic [SH_W-1:0]         ki_shift,
    input  logic [ACC_W-2:0]        samp_period,
    output logic signed [ACC_W-1:0] freq_est,
    output logic signed [ACC_W-1:0] rotor_angle,
    output logic                    drop_pulse,
    output logic                    insert_pulse
);
    logic err_ld, filt_en, acc_en, corr_en;
    logic signed [ACC_W-1:0] prop;

    tpll_ctrl u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (clr),
        .sym_stb (sym_stb),
        .err_ld  (err_ld),
        .filt_en (filt_en),
        .acc_en  (acc_en),
        .corr_en (corr_en)
    );

    tpll_loop_filter #(.ERR_W(ERR_W), .ACC_W(ACC_W), .SH_W(SH_W)) u_filt (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (clr),
        .err_ld    (err_ld),
        .filt_en   (filt_en),
        .phase_err (phase_err),
        .kp_shift  (kp_shift),
        .ki_shift  (ki_shift),
        .integ     (freq_est),
        .prop      (prop)
    );

    tpll_phase_acc #(.ACC_W(ACC_W)) u_acc (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (clr),
        .acc_en  (acc_en),
        .corr_en (corr_en),
        .integ   (freq_est),
        .prop    (prop),
        .period  (samp_period),
        .rotor   (rotor_angle),
        .drop    (drop_pulse),
        .ins     (insert_pulse)
    );

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |-> (!drop_pulse && !insert_pulse && rotor_angle == '0));
endmodule

// File: tb/sim_pilot_timing_pll.sv
module sim_pilot_timing_pll;
    localparam int ERR_W = 12;
    localparam int ACC_W = 16;
    localparam int SH_W  = 4;
    localparam int MAXV  = 2**(ACC_W-1) - 1;
    localparam int MINV  = -(2**(ACC_W-1));

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic clr = 1'b0;
    logic sym_stb = 1'b0;
    logic signed [ERR_W-1:0] phase_err = '0;
    logic [SH_W-1:0] kp_shift = '0;
    logic [SH_W-1:0] ki_shift = '0;
    logic [ACC_W-2:0] samp_period = '0;
    logic signed [ACC_W-1:0] freq_est, rotor_angle;
    logic drop_pulse, insert_pulse;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    pilot_timing_pll #(.ERR_W(ERR_W), .ACC_W(ACC_W), .SH_W(SH_W)) u0 (
        .clk(clk), .rst_n(rst_n), .clr(clr), .sym_stb(sym_stb),
        .phase_err(phase_err), .kp_shift(kp_shift), .ki_shift(ki_shift),
        .samp_period(samp_period), .freq_est(freq_est), .rotor_angle(rotor_angle),
        .drop_pulse(drop_pulse), .insert_pulse(insert_pulse)
    );

    // behavioural reference: expected outputs after each edge
    int m_int = 0, m_acc = 0, m_rot = 0, m_prop = 0, m_err = 0, m_phase = 0;
    bit m_drop = 0, m_ins = 0;

    function automatic int clamp(input int v);
        if (v > MAXV) return MAXV;
        if (v < MINV) return MINV;
        return v;
    endfunction

    always @(posedge clk) begin
        int p;
        p = int'(samp_period);
        if (!rst_n || clr) begin
            m_int = 0; m_acc = 0; m_rot = 0; m_prop = 0; m_err = 0;
            m_phase = 0; m_drop = 0; m_ins = 0;
        end else begin
            m_drop = 0;
            m_ins  = 0;
            if (m_phase == 0) begin
                if (sym_stb) begin
                    m_err = int'(phase_err);
                    m_phase = 1;
                end
            end else if (m_phase == 1) begin
                m_int  = clamp(m_int + (m_err >>> int'(ki_shift)));
                m_prop = m_err >>> int'(kp_shift);
                m_phase = 2;
            end else if (m_phase == 2) begin
                m_acc = clamp(m_acc + m_int + m_prop);
                m_phase = 3;
            end else begin
                if (m_acc > p) begin
                    m_acc = m_acc - p; m_drop = 1;
                end else if (m_acc < -p) begin
                    m_acc = m_acc + p; m_ins = 1;
                end
                m_rot = m_acc;
                m_phase = 0;
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    bit seen_drop, seen_ins;

    task automatic cyc();
        @(negedge clk);
        chk(int'(freq_est) == m_int, "R3 freq_est", int'(freq_est), m_int);
        chk(int'(rotor_angle) == m_rot, "R8 rotor_angle", int'(rotor_angle), m_rot);
        chk(drop_pulse == m_drop, "R5 drop_pulse", int'(drop_pulse), int'(m_drop));
        chk(insert_pulse == m_ins, "R6 insert_pulse", int'(insert_pulse), int'(m_ins));
        chk(!(drop_pulse && insert_pulse), "R9 exclusive", 1, 0);
        if (drop_pulse) seen_drop = 1;
        if (insert_pulse) seen_ins = 1;
    endtask

    task automatic sym(input int e);
        seen_drop = 0; seen_ins = 0;
        sym_stb = 1; phase_err = ERR_W'(e);
        cyc();
        sym_stb = 0;
        repeat (3) cyc();
    endtask

    task automatic do_clear();
        clr = 1; sym_stb = 1; phase_err = 12'sd300;
        cyc();
        clr = 0; sym_stb = 0;
    endtask

    initial begin
        #(4 * 150000);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        // R1 reset state
        samp_period = 15'd100; kp_shift = 0; ki_shift = 4'd15;
        repeat (3) cyc();
        chk(freq_est == 0 && rotor_angle == 0, "R1 reset values", int'(rotor_angle), 0);
        chk(!drop_pulse && !insert_pulse, "R1 reset pulses", int'(drop_pulse), 0);
        rst_n = 1;
        cyc();

        // R7 boundary: ki=15 keeps integrator at 0 for positive errors
        sym(100);
        chk(int'(rotor_angle) == 100 && !seen_drop, "R7 at +period", int'(rotor_angle), 100);
        sym(1);
        chk(seen_drop && int'(rotor_angle) == 1, "R5 drop past +period", int'(rotor_angle), 1);
        sym(-1);
        // negative error with ki=15 gives -1 into integrator: acc = 1 -1 -1 = -1
        chk(int'(rotor_angle) == -1 && int'(freq_est) == -1, "R4 sum", int'(rotor_angle), -1);
        kp_shift = 0; ki_shift = 4'd15;
        sym(-97);
        // integ -2, acc = -1 -2 -97 = -100
        chk(int'(rotor_angle) == -100 && !seen_ins, "R7 at -period", int'(rotor_angle), -100);
        sym(-1);
        // integ -3, acc = -100 -3 -1 = -104 -> insert, -4
        chk(seen_ins && int'(rotor_angle) == -4, "R6 insert past -period", int'(rotor_angle), -4);

        // R2: strobe held high while busy is ignored
        do_clear();
        chk(freq_est == 0 && rotor_angle == 0, "R10 clear", int'(rotor_angle), 0);
        cyc();
        sym_stb = 1; phase_err = 12'sd10;
        cyc();
        phase_err = 12'sd500;
        repeat (3) cyc();
        chk(int'(rotor_angle) == 10, "R2 busy strobes ignored", int'(rotor_angle), 10);
        sym_stb = 0;
        repeat (6) cyc();
        chk(int'(rotor_angle) == 10 && freq_est == 0, "R2 no extra symbol", int'(rotor_angle), 10);

        // R10: clear mid-symbol
        sym_stb = 1; phase_err = 12'sd50; cyc(); sym_stb = 0; cyc();
        clr = 1; cyc(); clr = 0;
        repeat (4) cyc();
        chk(rotor_angle == 0 && freq_est == 0, "R10 clear aborts symbol", int'(rotor_angle), 0);

        // PI tracking with drops then inserts
        samp_period = 15'd3000; kp_shift = 4'd2; ki_shift = 4'd6;
        begin
            int nd = 0, ni = 0;
            for (int i = 0; i < 60; i++) begin sym(700); if (seen_drop) nd++; end
            chk(nd > 0, "R5 drops under positive offset", nd, 1);
            for (int i = 0; i < 120; i++) begin sym(-900); if (seen_ins) ni++; end
            chk(ni > 0, "R6 inserts under negative offset", ni, 1);
        end

        // R3/R4 saturation
        do_clear();
        samp_period = 15'h7fff; kp_shift = 0; ki_shift = 0;
        for (int i = 0; i < 40; i++) sym(2047);
        chk(int'(freq_est) == MAXV, "R3 integrator high clamp", int'(freq_est), MAXV);
        chk(int'(rotor_angle) == MAXV, "R4 accumulator high clamp", int'(rotor_angle), MAXV);
        for (int i = 0; i < 80; i++) sym(-2048);
        chk(int'(freq_est) == MINV, "R3 integrator low clamp", int'(freq_est), MINV);

        // random symbols, gains and gaps
        do_clear();
        samp_period = 15'd2000;
        for (int i = 0; i < 300; i++) begin
            kp_shift = SH_W'($urandom_range(0, 15));
            ki_shift = SH_W'($urandom_range(0, 15));
            sym_stb = 1; phase_err = ERR_W'($urandom);
            cyc();
            sym_stb = 1'($urandom_range(0, 1));
            phase_err = ERR_W'($urandom);
            repeat ($urandom_range(3, 6)) cyc();
            sym_stb = 0;
            if ((i % 97) == 96) begin clr = 1; cyc(); clr = 0; end
        end
        repeat (8) cyc();

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule